// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Overflow Flag

This block performs one 32-bit saturating arithmetic operation per accepted request. A request presents two operands, an operation code and a saturation width on a single cycle with a valid strobe. One cycle later the block shows the clamped (or plain) result together with a one-cycle done pulse. Whenever an operation has to clamp, a sticky saturation flag is raised.

The operations cover signed and unsigned add and subtract with clamping, a signed add that only reports overflow and keeps the wrapped sum, a signed doubling of the first operand, signed and unsigned clamping of the first operand to a selectable bit width, and the same width clamping applied separately to both 16-bit halves of the first operand. The flag stays set until a separate clear strobe is given, so it can gather overflow events across a whole sequence of operations.

Top module: `sat_alu`

## Requirements
- R1: When `in_valid` is sampled high at a rising edge, `result` and `out_valid` are updated at that same edge, and `out_valid` is high for exactly one cycle per request. Without `in_valid`, `out_valid` is low and `result` keeps its value.
- R2: Op code 0 is signed add, op code 1 is signed subtract of `opb` from `opa`. On signed overflow the result is 0x7FFFFFFF when `opa` is non-negative and 0x80000000 when it is negative, and the flag is set; otherwise the wrapped result is returned.
- R3: Op code 2 returns the wrapped sum `opa + opb` unchanged, and sets the flag if the signed sum overflowed.
- R4: Op code 3 doubles `opa`: a signed value of at least 0x40000000 gives 0x7FFFFFFF, a signed value of at most 0xC0000000 gives 0x80000000, both setting the flag; any other value is shifted left by one.
- R5: Op code 4 is unsigned add, clamping to 0xFFFFFFFF when the sum wraps; op code 5 is unsigned subtract, clamping to 0 when `opb` exceeds `opa`. Clamping sets the flag.
- R6: Op code 6 clamps signed `opa` with width field n: if `opa` shifted arithmetically right by n is positive the result is 2^n-1, if it is below -1 the result is the bitwise inverse of 2^n-1 (both set the flag); otherwise `opa` passes.
- R7: Op code 7 clamps `opa` unsigned with width field n: a negative `opa` gives 0, a value above 2^n-1 gives 2^n-1 (both set the flag); otherwise `opa` passes.
- R8: Op codes 8 (signed rule of R6) and 9 (unsigned rule of R7) treat bits 15:0 and bits 31:16 of `opa` as two sign-extended halves, clamp each on its own, and place the low 16 bits of each result back in the same half; either half clamping sets the one shared flag.
- R9: No operation clears the flag. It is cleared only by `flag_clr`; if a clamping request and `flag_clr` arrive in the same cycle, the flag ends up set.
- R10: After reset `result` is 0, `out_valid` is 0 and `sat_flag` is 0.
- R11: Op codes 10 to 15 produce a result of 0 with the done pulse and leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| op | input | 4 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| sat_width | input | 5 | Bit width n for the width-clamping operations |
| flag_clr | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Done pulse, high one cycle after a request |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Every result, the done pulse and the flag change are due exactly one clock after the request is sampled, so the bench drives on the falling edge, lets one rising edge pass, and reads on the following falling edge. The cycle after that is read again to confirm the pulse has gone and the result held. Flag behaviour is observed on the `sat_flag` port in the same sampling slot, after sequences that mix clamping requests, non-clamping requests, clear strobes and unknown op codes.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [3:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_FADD   = 4'd2,
    OP_DBL    = 4'd3,
    OP_UADD   = 4'd4,
    OP_USUB   = 4'd5,
    OP_SCLAMP = 4'd6,
    OP_UCLAMP = 4'd7,
    OP_SCL16  = 4'd8,
    OP_UCL16  = 4'd9
  } sat_op_e;

  localparam logic [3:0] OP_LAST = 4'd9;

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
  import sat_pkg::*;
#(
  parameter int DW = 32
) (
  input  sat_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   res,
  output logic            hit
);

  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] QTR  = DW'(1) << (DW - 2);
  localparam logic [DW-1:0] NQTR = ~QTR + DW'(1);

  logic [DW-1:0] sum, diff;
  logic          s_add_ovf, s_sub_ovf;

  assign sum  = a + b;
  assign diff = a - b;

  // signed overflow: result sign departs from opa under the operand-sign rule
  assign s_add_ovf = (sum[DW-1]  ^ a[DW-1]) & ~(a[DW-1] ^ b[DW-1]);
  assign s_sub_ovf = (diff[DW-1] ^ a[DW-1]) &  (a[DW-1] ^ b[DW-1]);

  function automatic logic [DW-1:0] f_sclamp(input logic neg);
    return neg ? SMIN : SMAX;
  endfunction

  always_comb begin
    res = '0;
    hit = 1'b0;
    unique case (op)
      OP_SADD: begin
        hit = s_add_ovf;
        res = s_add_ovf ? f_sclamp(a[DW-1]) : sum;
      end
      OP_SSUB: begin
        hit = s_sub_ovf;
        res = s_sub_ovf ? f_sclamp(a[DW-1]) : diff;
      end
      OP_FADD: begin
        hit = s_add_ovf;
        res = sum;
      end
      OP_DBL: begin
        if ($signed(a) >= $signed(QTR)) begin
          hit = 1'b1;
          res = SMAX;
        end else if ($signed(a) <= $signed(NQTR)) begin
          hit = 1'b1;
          res = SMIN;
        end else begin
          res = {a[DW-2:0], 1'b0};
        end
      end
      OP_UADD: begin
        hit = (sum < a);
        res = hit ? '1 : sum;
      end
      OP_USUB: begin
        hit = (diff > a);
        res = hit ? '0 : diff;
      end
      default: begin
        res = '0;
        hit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
  import sat_pkg::*;
#(
  parameter int DW = 32,
  parameter int HW = 16,
  parameter int NW = 5
) (
  input  sat_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [NW-1:0]   n,
  output logic [DW-1:0]   res,
  output logic            hit
);

  localparam int LANES = DW / HW;

  // returns {clamped, value}
  function automatic logic [DW:0] f_sat_s(input logic [DW-1:0] v, input logic [NW-1:0] w);
    logic [DW-1:0]        m;
    logic signed [DW-1:0] top;
    m   = (DW'(1) << w) - DW'(1);
    top = $signed(v) >>> w;
    if (top > 0)       return {1'b1, m};
    else if (top < -1) return {1'b1, ~m};
    return {1'b0, v};
  endfunction

  function automatic logic [DW:0] f_sat_u(input logic [DW-1:0] v, input logic [NW-1:0] w);
    logic [DW-1:0] m;
    m = (DW'(1) << w) - DW'(1);
    if (v[DW-1])   return {1'b1, {DW{1'b0}}};
    else if (v > m) return {1'b1, m};
    return {1'b0, v};
  endfunction

  logic [DW:0]       full_s, full_u;
  logic [LANES-1:0]  lane_hit;
  logic [DW-1:0]     lane_pack;
  logic              lane_signed;

  assign full_s      = f_sat_s(a, n);
  assign full_u      = f_sat_u(a, n);
  assign lane_signed = (op == OP_SCL16);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] ext;
    logic [DW:0]   ls, lu;
    assign ext = {{(DW-HW){a[g*HW+HW-1]}}, a[g*HW +: HW]};
    assign ls  = f_sat_s(ext, n);
    assign lu  = f_sat_u(ext, n);
    assign lane_hit[g]            = lane_signed ? ls[DW] : lu[DW];
    assign lane_pack[g*HW +: HW]  = lane_signed ? ls[HW-1:0] : lu[HW-1:0];
  end

  always_comb begin
    res = '0;
    hit = 1'b0;
    unique case (op)
      OP_SCLAMP: begin
        res = full_s[DW-1:0];
        hit = full_s[DW];
      end
      OP_UCLAMP: begin
        res = full_u[DW-1:0];
        hit = full_u[DW];
      end
      OP_SCL16, OP_UCL16: begin
        res = lane_pack;
        hit = |lane_hit;
      end
      default: begin
        res = '0;
        hit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
#(
  parameter int DW = 32,
  parameter int HW = 16,
  localparam int NW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [NW-1:0] sat_width,
  input  logic          flag_clr,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          sat_flag
);

  sat_op_e       op_e;
  logic          op_known;
  logic          use_clamp;
  logic [DW-1:0] as_res, cl_res, sel_res;
  logic          as_hit, cl_hit;
  logic          sat_hit;
  logic          set_event;

  assign op_e      = sat_op_e'(op);
  assign op_known  = (op <= OP_LAST);
  assign use_clamp = (op >= OP_SCLAMP);

  sat_addsub #(.DW(DW)) u_addsub (
    .op  (op_e),
    .a   (opa),
    .b   (opb),
    .res (as_res),
    .hit (as_hit)
  );

  sat_clamp #(.DW(DW), .HW(HW), .NW(NW)) u_clamp (
    .op  (op_e),
    .a   (opa),
    .n   (sat_width),
    .res (cl_res),
    .hit (cl_hit)
  );

  assign sel_res   = !op_known ? '0 : (use_clamp ? cl_res : as_res);
  assign sat_hit   = op_known & (use_clamp ? cl_hit : as_hit);
  assign set_event = in_valid & sat_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= sel_res;
      if (set_event)     sat_flag <= 1'b1;
      else if (flag_clr) sat_flag <= 1'b0;
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R1
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_hit) |=> sat_flag); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !flag_clr) |=> sat_flag); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !set_event) |=> !sat_flag); // R9
  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_known) |=> (result == '0 && $stable(sat_flag))); // R11

endmodule

// File: tb/sat_alu_tb.sv
module sat_alu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  n;
    logic [31:0] exp;
    logic        hit;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd0, 32'h7fffffff, 32'h00000001, 5'd0, 32'h7fffffff, 1'b1},
    '{4'd0, 32'h80000000, 32'hffffffff, 5'd0, 32'h80000000, 1'b1},
    '{4'd0, 32'h00000005, 32'h00000003, 5'd0, 32'h00000008, 1'b0},
    '{4'd1, 32'h80000000, 32'h00000001, 5'd0, 32'h80000000, 1'b1},
    '{4'd1, 32'h7fffffff, 32'hffffffff, 5'd0, 32'h7fffffff, 1'b1},
    '{4'd1, 32'h00000010, 32'h00000020, 5'd0, 32'hfffffff0, 1'b0},
    '{4'd2, 32'h7fffffff, 32'h00000001, 5'd0, 32'h80000000, 1'b1},
    '{4'd2, 32'h00000001, 32'h00000002, 5'd0, 32'h00000003, 1'b0},
    '{4'd3, 32'h40000000, 32'h0,        5'd0, 32'h7fffffff, 1'b1},
    '{4'd3, 32'h3fffffff, 32'h0,        5'd0, 32'h7ffffffe, 1'b0},
    '{4'd3, 32'hc0000000, 32'h0,        5'd0, 32'h80000000, 1'b1},
    '{4'd3, 32'hc0000001, 32'h0,        5'd0, 32'h80000002, 1'b0},
    '{4'd4, 32'hffffffff, 32'h00000002, 5'd0, 32'hffffffff, 1'b1},
    '{4'd4, 32'hfffffffe, 32'h00000001, 5'd0, 32'hffffffff, 1'b0},
    '{4'd5, 32'h00000005, 32'h00000006, 5'd0, 32'h00000000, 1'b1},
    '{4'd5, 32'h00000006, 32'h00000006, 5'd0, 32'h00000000, 1'b0},
    '{4'd6, 32'h00000080, 32'h0,        5'd7, 32'h0000007f, 1'b1},
    '{4'd6, 32'h0000007f, 32'h0,        5'd7, 32'h0000007f, 1'b0},
    '{4'd6, 32'hffffff80, 32'h0,        5'd7, 32'hffffff80, 1'b0},
    '{4'd6, 32'hffffff7f, 32'h0,        5'd7, 32'hffffff80, 1'b1},
    '{4'd7, 32'hffffffff, 32'h0,        5'd8, 32'h00000000, 1'b1},
    '{4'd7, 32'h00000100, 32'h0,        5'd8, 32'h000000ff, 1'b1},
    '{4'd7, 32'h000000ff, 32'h0,        5'd8, 32'h000000ff, 1'b0},
    '{4'd8, 32'h00030008, 32'h0,        5'd3, 32'h00030007, 1'b1},
    '{4'd8, 32'hfff8fff7, 32'h0,        5'd3, 32'hfff8fff8, 1'b1},
    '{4'd8, 32'h0007fffc, 32'h0,        5'd3, 32'h0007fffc, 1'b0},
    '{4'd9, 32'h80000010, 32'h0,        5'd4, 32'h0000000f, 1'b1},
    '{4'd9, 32'h000f0005, 32'h0,        5'd4, 32'h000f0005, 1'b0},
    '{4'd11, 32'h12345678, 32'h1,       5'd3, 32'h00000000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [4:0]  sat_width = '0;
  logic        flag_clr = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        sat_flag;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_alu u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .sat_width (sat_width),
    .flag_clr  (flag_clr),
    .out_valid (out_valid),
    .result    (result),
    .sat_flag  (sat_flag)
  );

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0, 4'd1: return "R2";
      4'd2:       return "R3";
      4'd3:       return "R4";
      4'd4, 4'd5: return "R5";
      4'd6:       return "R6";
      4'd7:       return "R7";
      4'd8, 4'd9: return "R8";
      default:    return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one request on a falling edge, read it back one falling edge later
  task automatic issue(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] w, input logic clr);
    @(negedge clk);
    in_valid  = 1'b1;
    op        = c;
    opa       = a;
    opb       = b;
    sat_width = w;
    flag_clr  = clr;
    @(negedge clk);
    in_valid  = 1'b0;
    flag_clr  = 1'b0;
  endtask

  task automatic clear_only();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "result", result, 32'h0);
    chk("R10", "out_valid", {31'b0, out_valid}, 32'h1 - 32'h1);
    chk("R10", "flag", {31'b0, sat_flag}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "flag after release", {31'b0, sat_flag}, 32'h0);

    // table: clear with every request, so the flag equals this request's clamp
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].n, 1'b1);
      chk(tag_of(VECS[i].op), "result", result, VECS[i].exp);
      chk(tag_of(VECS[i].op), "flag", {31'b0, sat_flag}, {31'b0, VECS[i].hit});
      chk("R1", "done pulse", {31'b0, out_valid}, 32'h1);
      held = result;
      @(negedge clk);
      chk("R1", "done low", {31'b0, out_valid}, 32'h0);
      chk("R1", "result held", result, held);
    end

    // R9: flag survives a non-clamping request
    issue(4'd0, 32'h7fffffff, 32'h1, 5'd0, 1'b0);
    issue(4'd0, 32'h5, 32'h3, 5'd0, 1'b0);
    chk("R9", "sticky after plain add", {31'b0, sat_flag}, 32'h1);
    chk("R2", "plain add result", result, 32'h8);
    // R9: flag survives idle cycles
    repeat (3) @(negedge clk);
    chk("R9", "sticky idle", {31'b0, sat_flag}, 32'h1);
    // R11: unknown op leaves a set flag alone
    issue(4'd15, 32'hffffffff, 32'hffffffff, 5'd0, 1'b0);
    chk("R11", "unknown op result", result, 32'h0);
    chk("R11", "unknown op flag kept", {31'b0, sat_flag}, 32'h1);
    chk("R11", "unknown op done", {31'b0, out_valid}, 32'h1);
    // R9: clear strobe alone
    clear_only();
    chk("R9", "cleared", {31'b0, sat_flag}, 32'h0);
    // R11: unknown op does not set a clear flag
    issue(4'd10, 32'h7fffffff, 32'h1, 5'd0, 1'b0);
    chk("R11", "unknown op no set", {31'b0, sat_flag}, 32'h0);
    // R9: set wins over a simultaneous clear
    issue(4'd5, 32'h0, 32'h1, 5'd0, 1'b1);
    chk("R9", "set beats clear", {31'b0, sat_flag}, 32'h1);
    chk("R5", "usub clamp", result, 32'h0);
    // R8: only the high half clamps, flag still raised
    clear_only();
    issue(4'd8, 32'h7fff0001, 32'h0, 5'd4, 1'b0);
    chk("R8", "high half clamp", result, 32'h000f0001);
    chk("R8", "shared flag", {31'b0, sat_flag}, 32'h1);
    // R6: width 31 keeps any value
    issue(4'd6, 32'h80000000, 32'h0, 5'd31, 1'b1);
    chk("R6", "width 31 pass", result, 32'h80000000);
    chk("R6", "width 31 flag", {31'b0, sat_flag}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule